// File: doc/BRIEF.md
# Card Configuration Option Register and Task-File Address Decoder

This block holds the option register that a host uses to set up a removable storage card, and it turns host accesses into task-file register selects. The host reaches the option register through attribute space at offset 200h. The register holds three fields. One places the card in a held reset. One chooses how the card interrupt is signalled. One is a six-bit index that chooses the addressing scheme for the task-file registers.

From the index, the decoder maps each host memory or I/O access onto a 4-bit task-file register select and a hit flag. Four schemes are supported: a memory window, a contiguous I/O window, and two fixed legacy I/O ranges. The interrupt shaper takes an internal request and drives a low-true interrupt pin. In level mode the pin follows the request. In pulse mode each new request produces a fixed-length low pulse. A strap input puts the card in a disk-emulation mode, and in that mode the option register is locked out.

Top module: `cfg_tf_decoder`

## Requirements
- R1: After a hard reset (rst_n low) the option register holds 00h, card_rst is 0, irq_n is 1, and a read of offset 200h returns 00h.
- R2: A write with cfg_wr high at offset 200h updates the register on that clock edge. While cfg_rd is high at offset 200h, cfg_rdata shows the current register value combinationally. Reads at any other offset return 00h, and writes to any other offset leave the register unchanged.
- R3: Bit 7 is the soft reset. card_rst equals bit 7 combinationally, and it stays 1 until the host writes a value with bit 7 clear. Whenever bit 7 is already set or is being written as 1, bits 6:0 are stored as 0. As a result, the index returns to 000000 and the interrupt mode returns to pulse.
- R4: While card_rst is 1, tf_hit is 0.
- R5: With index 000000 (memory mode), a memory access (host_io=0) at host_addr 000h-00Fh or 400h-7FFh hits with tf_sel = host_addr[3:0]. A memory access at 010h-3FFh misses, and every I/O access misses.
- R6: With index 000001 (contiguous I/O), every I/O access hits with tf_sel = host_addr[3:0], and every memory access misses.
- R7: With index 000010 (primary legacy), an I/O access at 1F0h-1F7h hits with tf_sel = host_addr[2:0] (upper select bit 0). 3F6h hits with tf_sel Eh and 3F7h hits with tf_sel Fh. All 11 address bits are compared, and every other address misses.
- R8: With index 000011 (secondary legacy), the decode follows the R7 rule using 170h-177h, 376h and 377h.
- R9: With an index above 000011, or with host_sel low, tf_hit is 0.
- R10: While ide_strap is 1, writes to offset 200h are ignored and cfg_rdata is 00h.
- R11: In pulse mode (bit 6 = 0), a clock edge that samples irq_req high, when irq_req was low at the previous edge, drives irq_n low for exactly 8 cycles, starting right after that edge. A new rising edge during a pulse restarts the 8 cycles.
- R12: In level mode (bit 6 = 1), irq_n is the inverse of irq_req as sampled at the previous clock edge. While card_rst is 1, irq_n is held at 1 in both modes, and no request is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| ide_strap | input | 1 | Disk-emulation strap; locks the option register |
| cfg_wr | input | 1 | Attribute-space write strobe |
| cfg_rd | input | 1 | Attribute-space read strobe |
| cfg_addr | input | 12 | Attribute-space offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, 00h when not selected |
| card_rst | output | 1 | Internal card reset (soft reset bit) |
| host_sel | input | 1 | Host task-file access valid |
| host_io | input | 1 | 1 = I/O space, 0 = memory space |
| host_addr | input | 11 | Host address |
| tf_hit | output | 1 | Access targets a task-file register |
| tf_sel | output | 4 | Task-file register select |
| irq_req | input | 1 | Internal interrupt request |
| irq_n | output | 1 | Card interrupt, low true |

## Verification
The assertions assume that the strobes and host inputs are stable in the cycle before each clock edge. They also assume that hard reset is the only asynchronous input. The stimulus meets both conditions by changing every input just after the rising edge and reading results at the falling edge. The interrupt checks assume that irq_req is a clean synchronous level. The stimulus drives it from that same single point in each cycle, including rising edges that fall within a running pulse and requests made during soft reset. Decode sweeps are applied only after the index write has taken effect, so each address is judged against a settled mode.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam int HOST_AW  = 11;
  localparam int CFG_AW   = 12;
  localparam int REG_W    = 8;
  localparam int IDX_W    = 6;
  localparam int TF_SEL_W = 4;
  localparam int LEG_BLK_LSB = 3;  // 8-register block window
  localparam int LEG_CTL_LSB = 1;  // 2-register control window

  typedef enum logic [IDX_W-1:0] {
    MODE_MEM       = 6'd0,
    MODE_IO_CONTIG = 6'd1,
    MODE_IO_PRI    = 6'd2,
    MODE_IO_SEC    = 6'd3
  } tf_mode_e;

  typedef struct packed {
    logic             srst;
    logic             level;
    logic [IDX_W-1:0] idx;
  } opt_reg_t;

  typedef struct packed {
    logic                hit;
    logic [TF_SEL_W-1:0] sel;
  } tf_dec_t;

  // Memory window: low 16 bytes, or anywhere in the upper half.
  function automatic tf_dec_t dec_mem(input logic [HOST_AW-1:0] a);
    tf_dec_t r;
    r.hit = a[HOST_AW-1] || (a[HOST_AW-2:TF_SEL_W] == '0);
    r.sel = a[TF_SEL_W-1:0];
    return r;
  endfunction

  // Legacy pair: 8-register block plus 2-register control pair at Eh/Fh.
  function automatic tf_dec_t dec_legacy(input logic [HOST_AW-1:0] a,
                                         input logic [HOST_AW-1:0] blk,
                                         input logic [HOST_AW-1:0] ctl);
    tf_dec_t r;
    r = '0;
    if (a[HOST_AW-1:LEG_BLK_LSB] == blk[HOST_AW-1:LEG_BLK_LSB]) begin
      r.hit = 1'b1;
      r.sel = {1'b0, a[LEG_BLK_LSB-1:0]};
    end else if (a[HOST_AW-1:LEG_CTL_LSB] == ctl[HOST_AW-1:LEG_CTL_LSB]) begin
      r.hit = 1'b1;
      r.sel = {3'b111, a[0]};
    end
    return r;
  endfunction

  // Register update: while in (or entering) soft reset only bit 7 survives.
  function automatic opt_reg_t next_opt(input opt_reg_t cur,
                                        input logic [REG_W-1:0] wd);
    opt_reg_t n;
    n = opt_reg_t'(wd);
    if (cur.srst || n.srst) begin
      n.level = 1'b0;
      n.idx   = '0;
    end
    return n;
  endfunction

endpackage

// File: rtl/cfg_opt_reg.sv
module cfg_opt_reg
  import cfgdec_pkg::*;
#(
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ide_strap,
  input  logic              wr,
  input  logic              rd,
  input  logic [CFG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output opt_reg_t          opt_q
);

  logic addr_match;
  logic wr_en;
  logic rd_en;

  assign addr_match = (addr == CFG_OFFSET);
  assign wr_en      = wr && addr_match && !ide_strap;
  assign rd_en      = rd && addr_match && !ide_strap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= '0;
    end else if (wr_en) begin
      opt_q <= next_opt(opt_q, wdata);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) rdata = opt_q;
  end

endmodule

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
  import cfgdec_pkg::*;
#(
  parameter logic [HOST_AW-1:0] PRI_BLK = 11'h1F0,
  parameter logic [HOST_AW-1:0] PRI_CTL = 11'h3F6,
  parameter logic [HOST_AW-1:0] SEC_BLK = 11'h170,
  parameter logic [HOST_AW-1:0] SEC_CTL = 11'h376
) (
  input  logic                host_sel,
  input  logic                host_io,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [IDX_W-1:0]    idx,
  input  logic                blocked,
  output logic                hit,
  output logic [TF_SEL_W-1:0] sel
);

  localparam int N_LEG = 2;
  localparam logic [HOST_AW-1:0] BLK_TAB [N_LEG] = '{PRI_BLK, SEC_BLK};
  localparam logic [HOST_AW-1:0] CTL_TAB [N_LEG] = '{PRI_CTL, SEC_CTL};

  tf_dec_t mem_dec;
  tf_dec_t contig_dec;
  tf_dec_t leg_dec [N_LEG];
  tf_dec_t pick;

  assign mem_dec    = dec_mem(host_addr);
  assign contig_dec = '{hit: 1'b1, sel: host_addr[TF_SEL_W-1:0]};

  for (genvar w = 0; w < N_LEG; w++) begin : g_leg
    assign leg_dec[w] = dec_legacy(host_addr, BLK_TAB[w], CTL_TAB[w]);
  end

  always_comb begin
    pick = '0;
    case (idx)
      MODE_MEM:       if (!host_io) pick = mem_dec;
      MODE_IO_CONTIG: if (host_io)  pick = contig_dec;
      MODE_IO_PRI:    if (host_io)  pick = leg_dec[0];
      MODE_IO_SEC:    if (host_io)  pick = leg_dec[1];
      default:        pick = '0;
    endcase
  end

  assign hit = pick.hit && host_sel && !blocked;
  assign sel = pick.sel;

endmodule

// File: rtl/irq_shaper.sv
module irq_shaper #(
  parameter int PULSE_LEN = 8,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_rst,
  input  logic             level,
  input  logic             req,
  output logic             irq_n,
  output logic [CNT_W-1:0] cnt,
  output logic             rise
);

  logic req_q;

  assign rise = req && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt   <= '0;
    end else if (card_rst) begin
      req_q <= 1'b0;
      cnt   <= '0;
    end else begin
      req_q <= req;
      if (!level && rise) begin
        cnt <= CNT_W'(PULSE_LEN);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    if (card_rst)   irq_n = 1'b1;
    else if (level) irq_n = !req_q;
    else            irq_n = (cnt == '0);
  end

endmodule

// File: rtl/cfg_tf_decoder.sv
module cfg_tf_decoder
  import cfgdec_pkg::*;
#(
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 12'h200,
  parameter int                PULSE_LEN  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ide_strap,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  output logic                card_rst,
  input  logic                host_sel,
  input  logic                host_io,
  input  logic [HOST_AW-1:0]  host_addr,
  output logic                tf_hit,
  output logic [TF_SEL_W-1:0] tf_sel,
  input  logic                irq_req,
  output logic                irq_n
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  // Named internal events, also observed by the bound checker.
  opt_reg_t         opt_q;
  logic             level_mode;
  logic [CNT_W-1:0] pulse_cnt;
  logic             pulse_rise;

  cfg_opt_reg #(.CFG_OFFSET(CFG_OFFSET)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ide_strap (ide_strap),
    .wr        (cfg_wr),
    .rd        (cfg_rd),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .opt_q     (opt_q)
  );

  assign card_rst   = opt_q.srst;
  assign level_mode = opt_q.level;

  tf_addr_decode u_dec (
    .host_sel  (host_sel),
    .host_io   (host_io),
    .host_addr (host_addr),
    .idx       (opt_q.idx),
    .blocked   (card_rst),
    .hit       (tf_hit),
    .sel       (tf_sel)
  );

  irq_shaper #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_rst (card_rst),
    .level    (level_mode),
    .req      (irq_req),
    .irq_n    (irq_n),
    .cnt      (pulse_cnt),
    .rise     (pulse_rise)
  );

endmodule

// File: rtl/cfg_tf_checker.sv
module cfg_tf_checker
  import cfgdec_pkg::*;
#(
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 12'h200,
  parameter int                PULSE_LEN  = 8,
  localparam int               CNT_W      = $clog2(PULSE_LEN + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ide_strap,
  input logic                cfg_wr,
  input logic [CFG_AW-1:0]   cfg_addr,
  input opt_reg_t            opt_q,
  input logic                card_rst,
  input logic                tf_hit,
  input logic [TF_SEL_W-1:0] tf_sel,
  input logic                irq_req,
  input logic                irq_n,
  input logic                level_mode,
  input logic [CNT_W-1:0]    pulse_cnt,
  input logic                pulse_rise
);

  p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == CFG_OFFSET) |=> $stable(opt_q));

  p_srst_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q.srst |-> card_rst);

  p_srst_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q.srst |-> (opt_q.level == 1'b0 && opt_q.idx == '0));

  p_no_hit_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> !tf_hit);

  p_legacy_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_hit && (opt_q.idx == 6'd2 || opt_q.idx == 6'd3)) |->
      (!tf_sel[3] || tf_sel[3:1] == 3'b111));

  p_idx_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_q.idx > 6'd3) |-> !tf_hit);

  p_ide_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ide_strap |=> $stable(opt_q));

  p_pulse_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(PULSE_LEN));

  p_pulse_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pulse_rise && !card_rst) |=>
      (!irq_n || card_rst || level_mode));

  p_level_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !card_rst && $past(level_mode) && !$past(card_rst)) |->
      (irq_n == !$past(irq_req)));

endmodule

bind cfg_tf_decoder cfg_tf_checker #(
  .CFG_OFFSET(CFG_OFFSET),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ide_strap  (ide_strap),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .opt_q      (opt_q),
  .card_rst   (card_rst),
  .tf_hit     (tf_hit),
  .tf_sel     (tf_sel),
  .irq_req    (irq_req),
  .irq_n      (irq_n),
  .level_mode (level_mode),
  .pulse_cnt  (pulse_cnt),
  .pulse_rise (pulse_rise)
);

// File: tb/sim_cfg_tf_decoder.sv
module sim_cfg_tf_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ide_strap = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        card_rst;
  logic        host_sel = 1'b0, host_io = 1'b0;
  logic [10:0] host_addr = '0;
  logic        tf_hit;
  logic [3:0]  tf_sel;
  logic        irq_req = 1'b0;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_tf_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ide_strap(ide_strap),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .card_rst(card_rst),
    .host_sel(host_sel), .host_io(host_io), .host_addr(host_addr),
    .tf_hit(tf_hit), .tf_sel(tf_sel), .irq_req(irq_req), .irq_n(irq_n)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_reg = 8'h00;
  bit         m_req_prev = 0;
  int         m_low_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 8'h00; m_req_prev <= 0; m_low_left <= 0;
    end else begin
      started <= 1;
      if (cfg_wr && cfg_addr == 12'h200 && !ide_strap) begin
        if (m_reg[7] == 1'b1 || cfg_wdata[7] == 1'b1)
          m_reg <= cfg_wdata & 8'h80;
        else
          m_reg <= cfg_wdata;
      end
      if (m_reg[7]) begin
        m_req_prev <= 0; m_low_left <= 0;
      end else begin
        m_req_prev <= irq_req;
        if (m_reg[6] == 1'b0 && irq_req && !m_req_prev) m_low_left <= 8;
        else if (m_low_left > 0) m_low_left <= m_low_left - 1;
      end
    end
  end

  function automatic void expect_decode(input logic [7:0] r, input bit sel,
      input bit io, input int a, output bit hit, output int s,
      output string tag);
    int idx = int'(r[5:0]);
    hit = 0; s = 0;
    case (idx)
      0: tag = "R5";
      1: tag = "R6";
      2: tag = "R7";
      3: tag = "R8";
      default: tag = "R9";
    endcase
    if (!sel) begin tag = "R9"; return; end
    if (r[7]) begin tag = "R4"; return; end
    if (idx == 0 && !io) begin
      if (a < 16 || (a >= 1024 && a < 2048)) begin hit = 1; s = a % 16; end
    end else if (idx == 1 && io) begin
      hit = 1; s = a % 16;
    end else if ((idx == 2 || idx == 3) && io) begin
      int blk = (idx == 2) ? 'h1F0 : 'h170;
      int ctl = (idx == 2) ? 'h3F6 : 'h376;
      if (a >= blk && a <= blk + 7) begin hit = 1; s = a - blk; end
      else if (a == ctl)     begin hit = 1; s = 14; end
      else if (a == ctl + 1) begin hit = 1; s = 15; end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      bit eh; int es; string tg; int erd; bit eirq;
      check(card_rst == m_reg[7], "R3", "card_rst", card_rst, m_reg[7]);
      erd = (cfg_rd && cfg_addr == 12'h200 && !ide_strap) ? int'(m_reg) : 0;
      check(int'(cfg_rdata) == erd, ide_strap ? "R10" : "R2", "cfg_rdata",
            cfg_rdata, erd);
      expect_decode(m_reg, host_sel, host_io, int'(host_addr), eh, es, tg);
      check(tf_hit == eh, tg, "tf_hit", tf_hit, eh);
      if (eh) check(int'(tf_sel) == es, tg, "tf_sel", tf_sel, es);
      if (m_reg[7])      eirq = 1;
      else if (m_reg[6]) eirq = !m_req_prev;
      else               eirq = (m_low_left == 0);
      check(irq_n == eirq, m_reg[6] ? "R12" : "R11", "irq_n", irq_n, eirq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_opt(input logic [11:0] a, input logic [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_wr = 0; cfg_addr = 12'h200; cfg_rd = 1;
    step(1);
  endtask

  task automatic sweep();
    int addrs [24] = '{'h000, 'h005, 'h00F, 'h010, 'h1EF, 'h1F0, 'h1F3,
                       'h1F7, 'h1F8, 'h3F5, 'h3F6, 'h3F7, 'h3F8, 'h16F,
                       'h170, 'h177, 'h178, 'h376, 'h377, 'h3FF, 'h400,
                       'h5F0, 'h7F6, 'h7FF};
    host_sel = 1;
    foreach (addrs[i]) begin
      for (int io = 0; io < 2; io++) begin
        host_addr = 11'(addrs[i]); host_io = io[0];
        step(1);
      end
    end
    host_sel = 0; host_addr = 11'h1F0; host_io = 1;
    step(1);
  endtask

  task automatic irq_pattern();
    irq_req = 1; step(3);
    irq_req = 0; step(2);
    irq_req = 1; step(1);
    irq_req = 0; step(4);
    irq_req = 1; step(1);   // retrigger inside a running pulse
    irq_req = 0; step(12);
    irq_req = 1; step(14);  // long request, single pulse
    irq_req = 0; step(3);
  endtask

  initial begin
    step(3);
    cfg_rd = 1; cfg_addr = 12'h200;
    step(1);
    // R1: reset state seen at the ports
    check(cfg_rdata == 8'h00 && irq_n && !card_rst, "R1", "reset state",
          {cfg_rdata, 3'b0, irq_n, 3'b0, card_rst}, 'h0010);
    rst_n = 1;
    step(2);

    // R12 level mode, then R11 pulse mode
    wr_opt(12'h200, 8'h40);
    irq_pattern();
    wr_opt(12'h200, 8'h00);
    irq_pattern();

    // R5..R9 decode under each index value
    for (int m = 0; m < 6; m++) begin
      wr_opt(12'h200, (m < 4) ? 8'(m) : ((m == 4) ? 8'h04 : 8'h3F));
      sweep();
    end

    // R2: other offsets are not the register
    wr_opt(12'h200, 8'h41);
    wr_opt(12'h202, 8'h02);
    cfg_addr = 12'h202; step(1);
    cfg_addr = 12'h200; step(1);
    check(cfg_rdata == 8'h41, "R2", "offset 202h write ignored", cfg_rdata, 'h41);

    // R3/R4: soft reset holds, clears low bits, blocks decode and irq
    wr_opt(12'h200, 8'hC3);
    check(cfg_rdata == 8'h80 && card_rst, "R3", "soft reset value", cfg_rdata, 'h80);
    host_sel = 1; host_io = 0; host_addr = 11'h003; step(1);
    check(!tf_hit, "R4", "no hit in soft reset", tf_hit, 0);
    irq_req = 1; step(3); irq_req = 0; step(1);
    wr_opt(12'h200, 8'h42);   // leaves reset; low bits dropped
    check(cfg_rdata == 8'h00 && !card_rst, "R3", "exit soft reset", cfg_rdata, 'h00);
    wr_opt(12'h200, 8'h02);
    sweep();

    // R10: strap locks the register
    ide_strap = 1;
    wr_opt(12'h200, 8'h01);
    check(cfg_rdata == 8'h00, "R10", "rdata blanked", cfg_rdata, 0);
    ide_strap = 0; step(1);
    check(cfg_rdata == 8'h02, "R10", "write ignored", cfg_rdata, 'h02);

    // R1: hard reset mid-run clears a set soft reset
    wr_opt(12'h200, 8'h80);
    rst_n = 0; step(1);
    check(cfg_rdata == 8'h00 && !card_rst, "R1", "hard reset", cfg_rdata, 0);
    rst_n = 1; step(2);
    sweep();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule